// File: doc/BRIEF.md
# Byte Command Decoder with Configuration Registers

This block sits between a serial receiver and a serial transmitter. Each byte that arrives is one complete command. The block decodes the byte through a hierarchical opcode map. The command then does one of three things: it updates a configuration register, it returns one response byte, or it does nothing at all. The registers it keeps are the six 2-bit sensor masks (enable, complement, high, low, rising, falling), an alternate-mode flag, an oscillator trim byte, a saturating glitch counter and the read index into a fixed identification string. The sensor input byte and the interrupt enable and pending flags belong to neighbouring logic. This block reads those values and drives one-cycle write strobes back to their owners.

Both streams use valid/ready handshakes. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. If the command produces a response, `rsp_valid` rises in the next cycle. `rsp_data` then stays stable until a clock edge where `rsp_ready` is high. `cmd_ready` is low for as long as a response is waiting. The transmitter can therefore stall the receiver side for any length of time and no byte is lost.

Top module: `cmd_decoder_regs`

## Requirements
- R1: `cmd_ready` is low whenever `rsp_valid` is high. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values, and commands offered during the stall are not accepted.
- R2: After reset, enable = 2'b11 and the complement, high, low, rising and falling masks are 0. The alternate flag is 0, the trim byte is TRIM_INIT, the glitch counter is 0, the identification index is 0, and `rsp_valid` is low.
- R3: 0x00 returns (sensor XOR complement) AND 0x0F, with the complement mask placed in bits 1:0. 0x01 returns the raw sensor byte. 0x02 returns the alternate flag as 0 or 1.
- R4: Commands 0001eecc, 0010hhll and 0011rrff load the named mask pair from bits 3:2 and bits 1:0. 0x03, 0x04 and 0x05 return {enable,complement}, {high,low} and {rising,falling} in bits 3:0, with the first-named mask in bits 3:2.
- R5: 0x06 and 0x07 set the alternate flag to command bit 0.
- R6: Commands 0x08–0x0F, 0x40–0xBF, 0xC0–0xE7 and 0xE8–0xEE produce no response, change no register and pulse no strobe.
- R7: 0xEF returns a byte with the interrupt enable input in bit 1 and the interrupt pending input in bit 0.
- R8: 0xF0–0xF3 write enable from bit 1 and pending from bit 0. 0xF4–0xF5 write pending only, from bit 0. 0xF6–0xF7 write enable only, from bit 0. Each write is a one-cycle strobe in the cycle after the command is accepted.
- R9: 0xF8 lowers the trim byte by TRIM_STEP and 0xF9 raises it, both modulo 256. 0xFA returns the trim byte and 0xFB returns 0.
- R10: Identification byte i equals (ID_BASE + i*ID_STEP) mod 256 for i from 0 to ID_LEN-1. 0xFC returns the byte at the current index and then advances the index, wrapping from ID_LEN-1 to 0. 0xFD sets the index to 0 without responding.
- R11: 0xFF increments the glitch counter and saturates at 0xFF. 0xFE returns the counter and then clears it.
- R12: A responding command asserts `rsp_valid` in the cycle immediately after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Decoder can accept a command |
| cmd_data | input | 8 | Command byte |
| rsp_valid | output | 1 | Response byte waiting |
| rsp_ready | input | 1 | Transmitter takes the response |
| rsp_data | output | 8 | Response byte |
| sense_raw | input | 8 | Sensor input value from the sequencer |
| irq_en_i | input | 1 | Current interrupt enable flag |
| irq_pend_i | input | 1 | Current interrupt pending flag |
| irq_en_we | output | 1 | Write strobe for the interrupt enable flag |
| irq_en_wd | output | 1 | Value written to the interrupt enable flag |
| irq_pend_we | output | 1 | Write strobe for the interrupt pending flag |
| irq_pend_wd | output | 1 | Value written to the interrupt pending flag |
| en_mask | output | 2 | Enable mask |
| cmp_mask | output | 2 | Complement mask |
| hi_mask | output | 2 | High-level mask |
| lo_mask | output | 2 | Low-level mask |
| rise_mask | output | 2 | Rising-edge mask |
| fall_mask | output | 2 | Falling-edge mask |
| alt_mode | output | 1 | Alternate flag |
| trim | output | 8 | Oscillator trim byte |

## Verification
A mask or flag that holds a wrong value shows up on its output pin in the cycle after the faulty command. It also shows up in the matching readback byte one cycle after the read is accepted. Errors in the glitch counter and the identification index stay hidden until the next 0xFE or 0xFC. The tests therefore read those registers back right after each boundary: saturation, the clear-on-read, the index wrap and the index reset. A decode slip into an ignored range shows as an unexpected `rsp_valid` or strobe in the cycle after acceptance.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  localparam int BYTE_W = 8;
  localparam int PAIR_W = 2;

  typedef enum logic [4:0] {
    OP_NONE,
    OP_RD_IN,
    OP_RD_RAW,
    OP_RD_ALT,
    OP_RD_EC,
    OP_RD_HL,
    OP_RD_RF,
    OP_WR_ALT,
    OP_WR_EC,
    OP_WR_HL,
    OP_WR_RF,
    OP_RD_IRQ,
    OP_WR_IRQ,
    OP_WR_PEND,
    OP_WR_IEN,
    OP_TRIM_DN,
    OP_TRIM_UP,
    OP_RD_TRIM,
    OP_PULSE,
    OP_ID_NEXT,
    OP_ID_RST,
    OP_GL_RD,
    OP_GL_INC
  } op_e;

  // Three-level opcode tree: class in [7:6], group in [5:3], leaf in [2:0].
  function automatic op_e classify(input logic [BYTE_W-1:0] c);
    op_e o;
    o = OP_NONE;
    unique case (c[7:6])
      2'b00: begin
        unique case (c[5:3])
          3'd0: begin
            unique case (c[2:0])
              3'd0: o = OP_RD_IN;
              3'd1: o = OP_RD_RAW;
              3'd2: o = OP_RD_ALT;
              3'd3: o = OP_RD_EC;
              3'd4: o = OP_RD_HL;
              3'd5: o = OP_RD_RF;
              default: o = OP_WR_ALT;
            endcase
          end
          3'd1: o = OP_NONE;
          3'd2, 3'd3: o = OP_WR_EC;
          3'd4, 3'd5: o = OP_WR_HL;
          default: o = OP_WR_RF;
        endcase
      end
      2'b11: begin
        unique case (c[5:3])
          3'd5: o = (c[2:0] == 3'd7) ? OP_RD_IRQ : OP_NONE;
          3'd6: begin
            if (!c[2])      o = OP_WR_IRQ;
            else if (!c[1]) o = OP_WR_PEND;
            else            o = OP_WR_IEN;
          end
          3'd7: begin
            unique case (c[2:0])
              3'd0: o = OP_TRIM_DN;
              3'd1: o = OP_TRIM_UP;
              3'd2: o = OP_RD_TRIM;
              3'd3: o = OP_PULSE;
              3'd4: o = OP_ID_NEXT;
              3'd5: o = OP_ID_RST;
              3'd6: o = OP_GL_RD;
              default: o = OP_GL_INC;
            endcase
          end
          default: o = OP_NONE;
        endcase
      end
      default: o = OP_NONE;
    endcase
    return o;
  endfunction

  function automatic logic has_reply(input op_e o);
    return o inside {OP_RD_IN, OP_RD_RAW, OP_RD_ALT, OP_RD_EC, OP_RD_HL,
                     OP_RD_RF, OP_RD_IRQ, OP_RD_TRIM, OP_PULSE, OP_ID_NEXT,
                     OP_GL_RD};
  endfunction

endpackage

// File: rtl/cdr_decode.sv
module cdr_decode
  import cdr_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output op_e               op,
  output logic              replies
);
  always_comb begin
    op      = classify(cmd);
    replies = has_reply(op);
  end
endmodule

// File: rtl/cdr_cfg_regs.sv
module cdr_cfg_regs
  import cdr_pkg::*;
#(
  parameter logic [7:0] TRIM_INIT = 8'h80,
  parameter int         TRIM_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  op_e               op,
  input  logic [BYTE_W-1:0] cmd,
  output logic [PAIR_W-1:0] en_q,
  output logic [PAIR_W-1:0] cmp_q,
  output logic [PAIR_W-1:0] hi_q,
  output logic [PAIR_W-1:0] lo_q,
  output logic [PAIR_W-1:0] rise_q,
  output logic [PAIR_W-1:0] fall_q,
  output logic              alt_q,
  output logic [BYTE_W-1:0] trim_q
);
  localparam logic [BYTE_W-1:0] STEP = BYTE_W'(TRIM_STEP);

  logic [PAIR_W-1:0] upper, lower;
  assign upper = cmd[2*PAIR_W-1:PAIR_W];
  assign lower = cmd[PAIR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '1;
      cmp_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= 1'b0;
      trim_q <= TRIM_INIT;
    end else if (take) begin
      unique case (op)
        OP_WR_EC:   begin en_q   <= upper; cmp_q  <= lower; end
        OP_WR_HL:   begin hi_q   <= upper; lo_q   <= lower; end
        OP_WR_RF:   begin rise_q <= upper; fall_q <= lower; end
        OP_WR_ALT:  alt_q  <= cmd[0];
        OP_TRIM_DN: trim_q <= trim_q - STEP;
        OP_TRIM_UP: trim_q <= trim_q + STEP;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cdr_aux.sv
module cdr_aux
  import cdr_pkg::*;
#(
  parameter int         ID_LEN  = 5,
  parameter logic [7:0] ID_BASE = 8'h31,
  parameter logic [7:0] ID_STEP = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  op_e               op,
  output logic [BYTE_W-1:0] glitch_q,
  output logic [BYTE_W-1:0] id_byte
);
  localparam int IDX_W = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_LEN - 1);

  logic [BYTE_W-1:0] id_tab [ID_LEN];
  logic [IDX_W-1:0]  idx_q;

  for (genvar g = 0; g < ID_LEN; g++) begin : g_id
    assign id_tab[g] = BYTE_W'(int'(ID_BASE) + g * int'(ID_STEP));
  end

  assign id_byte = id_tab[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      glitch_q <= '0;
    end else if (take) begin
      unique case (op)
        OP_ID_NEXT: idx_q    <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        OP_ID_RST:  idx_q    <= '0;
        OP_GL_RD:   glitch_q <= '0;
        OP_GL_INC:  if (glitch_q != '1) glitch_q <= glitch_q + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_decoder_regs.sv
module cmd_decoder_regs
  import cdr_pkg::*;
#(
  parameter logic [7:0] TRIM_INIT = 8'h80,
  parameter int         TRIM_STEP = 4,
  parameter int         ID_LEN    = 5,
  parameter logic [7:0] ID_BASE   = 8'h31,
  parameter logic [7:0] ID_STEP   = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  input  logic [7:0] sense_raw,
  input  logic       irq_en_i,
  input  logic       irq_pend_i,
  output logic       irq_en_we,
  output logic       irq_en_wd,
  output logic       irq_pend_we,
  output logic       irq_pend_wd,
  output logic [1:0] en_mask,
  output logic [1:0] cmp_mask,
  output logic [1:0] hi_mask,
  output logic [1:0] lo_mask,
  output logic [1:0] rise_mask,
  output logic [1:0] fall_mask,
  output logic       alt_mode,
  output logic [7:0] trim
);
  localparam int PAD_IN   = BYTE_W - PAIR_W;
  localparam int PAD_PAIR = BYTE_W - 2 * PAIR_W;

  op_e               op;
  logic              replies;
  logic              take;
  logic [BYTE_W-1:0] glitch, id_byte, reply;

  assign cmd_ready = !rsp_valid;
  assign take      = cmd_valid && cmd_ready;

  cdr_decode u_dec (.cmd(cmd_data), .op(op), .replies(replies));

  cdr_cfg_regs #(.TRIM_INIT(TRIM_INIT), .TRIM_STEP(TRIM_STEP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .take(take), .op(op), .cmd(cmd_data),
    .en_q(en_mask), .cmp_q(cmp_mask), .hi_q(hi_mask), .lo_q(lo_mask),
    .rise_q(rise_mask), .fall_q(fall_mask), .alt_q(alt_mode), .trim_q(trim)
  );

  cdr_aux #(.ID_LEN(ID_LEN), .ID_BASE(ID_BASE), .ID_STEP(ID_STEP)) u_aux (
    .clk(clk), .rst_n(rst_n), .take(take), .op(op),
    .glitch_q(glitch), .id_byte(id_byte)
  );

  always_comb begin
    unique case (op)
      OP_RD_IN:   reply = (sense_raw ^ {{PAD_IN{1'b0}}, cmp_mask}) & 8'h0F;
      OP_RD_RAW:  reply = sense_raw;
      OP_RD_ALT:  reply = {{(BYTE_W-1){1'b0}}, alt_mode};
      OP_RD_EC:   reply = {{PAD_PAIR{1'b0}}, en_mask, cmp_mask};
      OP_RD_HL:   reply = {{PAD_PAIR{1'b0}}, hi_mask, lo_mask};
      OP_RD_RF:   reply = {{PAD_PAIR{1'b0}}, rise_mask, fall_mask};
      OP_RD_IRQ:  reply = {{(BYTE_W-2){1'b0}}, irq_en_i, irq_pend_i};
      OP_RD_TRIM: reply = trim;
      OP_ID_NEXT: reply = id_byte;
      OP_GL_RD:   reply = glitch;
      default:    reply = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && replies) begin
      rsp_valid <= 1'b1;
      rsp_data  <= reply;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_we   <= 1'b0;
      irq_en_wd   <= 1'b0;
      irq_pend_we <= 1'b0;
      irq_pend_wd <= 1'b0;
    end else begin
      irq_en_we   <= take && (op == OP_WR_IRQ || op == OP_WR_IEN);
      irq_pend_we <= take && (op == OP_WR_IRQ || op == OP_WR_PEND);
      irq_en_wd   <= (op == OP_WR_IRQ) ? cmd_data[1] : cmd_data[0];
      irq_pend_wd <= cmd_data[0];
    end
  end
endmodule

// File: rtl/cdr_checker.sv
module cdr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       irq_en_we,
  input logic       irq_pend_we,
  input logic       alt_mode,
  input logic [7:0] trim
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R1
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R1
  AST_RSP_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc)); // R12
  AST_ALT_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alt_mode) |-> $past(acc)); // R5
  AST_TRIM_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim) |-> ((trim - $past(trim)) == 8'd4 || ($past(trim) - trim) == 8'd4)); // R9
  AST_STROBE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_we || irq_pend_we) |-> $past(acc)); // R8
endmodule

bind cmd_decoder_regs cdr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .irq_en_we(irq_en_we), .irq_pend_we(irq_pend_we),
  .alt_mode(alt_mode), .trim(trim)
);

// File: tb/tb_cmd_decoder_regs.sv
module tb_cmd_decoder_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] T_INIT = 8'h80;
  localparam int ID_N = 5;
  localparam int ID_B = 8'h31;
  localparam int ID_S = 8'h11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [7:0] cmd_data = '0, sense_raw = '0;
  logic irq_en_i = 1'b0, irq_pend_i = 1'b0;
  logic cmd_ready, rsp_valid, irq_en_we, irq_en_wd, irq_pend_we, irq_pend_wd, alt_mode;
  logic [7:0] rsp_data, trim;
  logic [1:0] en_mask, cmp_mask, hi_mask, lo_mask, rise_mask, fall_mask;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_decoder_regs dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .sense_raw(sense_raw), .irq_en_i(irq_en_i),
    .irq_pend_i(irq_pend_i), .irq_en_we(irq_en_we), .irq_en_wd(irq_en_wd),
    .irq_pend_we(irq_pend_we), .irq_pend_wd(irq_pend_wd), .en_mask(en_mask),
    .cmp_mask(cmp_mask), .hi_mask(hi_mask), .lo_mask(lo_mask),
    .rise_mask(rise_mask), .fall_mask(fall_mask), .alt_mode(alt_mode), .trim(trim)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] idb(input int i);
    return 8'(ID_B + i * ID_S);
  endfunction

  // Offer one command; returns at the negedge after the accepting edge.
  task automatic send(input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic ask(input logic [7:0] c, input logic [7:0] exp, input string tag);
    send(c);
    chk({tag, " rsp_valid"}, rsp_valid, 1);   // R12
    chk({tag, " rsp_data"}, rsp_data, exp);
    drain();
    chk({tag, " drained"}, rsp_valid, 0);
  endtask

  task automatic quiet(input logic [7:0] c, input string tag);
    send(c);
    chk({tag, " no rsp"}, rsp_valid, 0);
    chk({tag, " no strobe"}, irq_en_we | irq_pend_we, 0);
  endtask

  task automatic t_reset();
    chk("R2 en", en_mask, 3);
    chk("R2 masks", {cmp_mask, hi_mask, lo_mask, rise_mask, fall_mask}, 0);
    chk("R2 alt", alt_mode, 0);
    chk("R2 trim", trim, T_INIT);
    chk("R2 rsp_valid", rsp_valid, 0);
    ask(8'hFE, 8'h00, "R2 glitch");
    ask(8'hFC, idb(0), "R2 id index");
    quiet(8'hFD, "R10 id reset");
  endtask

  task automatic t_inputs();
    sense_raw = 8'hA6;
    ask(8'h01, 8'hA6, "R3 raw");
    ask(8'h00, 8'h06, "R3 inputs comp0");
    send(8'h1E); // en=3 comp=2
    chk("R4 en out", en_mask, 3);
    chk("R4 cmp out", cmp_mask, 2);
    ask(8'h00, 8'h04, "R3 inputs comp2");
    ask(8'h03, 8'h0E, "R4 read ec");
  endtask

  task automatic t_masks();
    send(8'h29);
    chk("R4 hi", hi_mask, 2);
    chk("R4 lo", lo_mask, 1);
    ask(8'h04, 8'h09, "R4 read hl");
    send(8'h37);
    chk("R4 rise", rise_mask, 1);
    chk("R4 fall", fall_mask, 3);
    ask(8'h05, 8'h07, "R4 read rf");
  endtask

  task automatic t_alt();
    send(8'h07);
    chk("R5 alt set", alt_mode, 1);
    ask(8'h02, 8'h01, "R5 read alt");
    send(8'h06);
    chk("R5 alt clr", alt_mode, 0);
    ask(8'h02, 8'h00, "R3 read alt");
  endtask

  task automatic t_ignored();
    logic [7:0] ign [9] = '{8'h08, 8'h0F, 8'h40, 8'h80, 8'hBF, 8'hC0, 8'hE7, 8'hE8, 8'hEE};
    foreach (ign[i]) quiet(ign[i], "R6 ignored");
    chk("R6 masks kept", {en_mask, cmp_mask, hi_mask, lo_mask, rise_mask, fall_mask}, 12'hE97);
    chk("R6 trim kept", trim, T_INIT);
    ask(8'hFE, 8'h00, "R6 glitch kept");
  endtask

  task automatic t_irq();
    irq_en_i = 1'b1; irq_pend_i = 1'b0;
    ask(8'hEF, 8'h02, "R7 irq en");
    irq_en_i = 1'b0; irq_pend_i = 1'b1;
    ask(8'hEF, 8'h01, "R7 irq pend");
    send(8'hF2);
    chk("R8 both we", {irq_en_we, irq_pend_we}, 2'b11);
    chk("R8 both wd", {irq_en_wd, irq_pend_wd}, 2'b10);
    @(negedge clk);
    chk("R8 one cycle", irq_en_we | irq_pend_we, 0);
    send(8'hF5);
    chk("R8 pend only", {irq_en_we, irq_pend_we, irq_pend_wd}, 3'b011);
    send(8'hF6);
    chk("R8 en only", {irq_en_we, irq_pend_we, irq_en_wd}, 3'b100);
  endtask

  task automatic t_trim();
    send(8'hF8); send(8'hF8); send(8'hF9);
    chk("R9 trim out", trim, 8'h7C);
    ask(8'hFA, 8'h7C, "R9 read trim");
    for (int i = 0; i < 33; i++) send(8'hF9);
    ask(8'hFA, 8'h00, "R9 trim wrap");
    ask(8'hFB, 8'h00, "R9 pulse");
  endtask

  task automatic t_id();
    for (int i = 0; i < ID_N + 2; i++) ask(8'hFC, idb(i % ID_N), "R10 id walk");
    quiet(8'hFD, "R10 reset");
    ask(8'hFC, idb(0), "R10 after reset");
    quiet(8'hFD, "R10 reset2");
  endtask

  task automatic t_glitch();
    for (int i = 0; i < 3; i++) send(8'hFF);
    ask(8'hFE, 8'h03, "R11 count");
    ask(8'hFE, 8'h00, "R11 cleared");
    for (int i = 0; i < 300; i++) send(8'hFF);
    ask(8'hFE, 8'hFF, "R11 saturate");
  endtask

  task automatic t_stall();
    send(8'h03);
    cmd_valid = 1'b1; cmd_data = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 held valid", rsp_valid, 1);
      chk("R1 held data", rsp_data, 8'h0E);
      chk("R1 not ready", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    drain();
    chk("R1 released", rsp_valid, 0);
    ask(8'hFE, 8'h00, "R1 stalled cmd dropped");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inputs();
    t_masks();
    t_alt();
    t_ignored();
    t_irq();
    t_trim();
    t_id();
    t_glitch();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule